// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block keeps the two threshold offsets that a FIFO's programmable flag logic compares against: one for the almost-empty flag and one for the almost-full flag. While master reset is held, a single load-select pin picks the programming method and the default value for both offsets. Parallel mode starts both offsets at a small default. Serial mode starts both offsets at a large default. After reset, software programs new offsets on the write clock. In parallel mode it writes whole words from the write data bus. In serial mode it shifts in one bit per enabled edge. On the read clock it can read the offsets back one word at a time on the read data bus.

The write-domain offsets go straight to the full-side flag logic. A snapshot of them crosses to the read clock through a toggle request/acknowledge handshake. The empty-side flag logic and the readback path use only this stable read-domain copy. Partial reset only rewinds the word and bit indices. The offsets and the chosen method stay as they are. The block has no streaming interface. All pins are plain control and data levels sampled on rising clock edges, so there is no back-pressure.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst` is high at a rising `wclk` edge, the method and both write-domain offsets are set: `ld`=0 gives parallel mode (`ser_mode`=0) and both offsets equal DEF_PAR; `ld`=1 gives serial mode (`ser_mode`=1) and both offsets equal DEF_SER. While `mrst` is high at a rising `rclk` edge, the read-domain copies take the same default and `rq` clears to 0.
- R2: In parallel mode, a rising `wclk` edge with `wen`=1 and `ld`=1 copies `wdata` into the almost-empty offset on the first load after reset. The next such load goes into the almost-full offset, and the target keeps alternating. The new value is visible on the write-domain outputs after that edge.
- R3: In parallel mode, `sen` and `si` have no effect on either offset.
- R4: In serial mode, each rising `wclk` edge with `sen`=1 and `ld`=1 stores `si` at bit k of the 2*W-bit word {almost-full, almost-empty}. Here k counts 0..2*W-1 from reset and then wraps to 0. So the first W bits fill the almost-empty offset LSB first, and the next W bits fill the almost-full offset LSB first.
- R5: In serial mode, `wen` together with `ld` has no effect on either offset.
- R6: A rising `rclk` edge with `ren`=1 and `ld`=1 places a read-domain offset on `rq` after that edge. The first read after a reset returns almost-empty, the next returns almost-full, and the reads keep alternating. This works in either mode. With no such edge, `rq` holds its value.
- R7: The read-domain copies change only by taking the whole handshake snapshot. That snapshot is frozen while a transfer is in flight. Within 30 `wclk` cycles after the last load, both copies equal the write-domain offsets.
- R8: Partial reset (`prst`=1, `mrst`=0) leaves both offsets and `ser_mode` unchanged and blocks loads on that edge. It returns the parallel target, the serial bit index and the readback index to the almost-empty side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled in both clock domains |
| prst | input | 1 | Partial reset, active high, sampled in both clock domains |
| ld | input | 1 | Load select: chooses the method during master reset, qualifies loads and reads afterwards |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial data bit |
| wen | input | 1 | Parallel write enable |
| wdata | input | W | Parallel offset word |
| ren | input | 1 | Readback enable |
| rq | output | W | Readback offset word |
| ser_mode | output | 1 | 1 when serial programming was selected |
| wr_ae_ofs | output | W | Almost-empty offset, write domain |
| wr_af_ofs | output | W | Almost-full offset, write domain |
| rd_ae_ofs | output | W | Almost-empty offset, read domain copy |
| rd_af_ofs | output | W | Almost-full offset, read domain copy |

## Verification
The bench builds the block with W=4, DEF_PAR=7 and DEF_SER=13. With this narrow offset width, every one of the 256 almost-empty/almost-full value pairs can be loaded in both parallel and serial mode. Each pair is then checked on the write-domain outputs, the read-domain copies and the alternating readback. The two defaults differ and both fit in four bits, so a swapped method or default shows up straight after master reset. The read clock runs at a period unrelated to the write clock, which moves the handshake's phase from one transfer to the next.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  typedef enum logic {
    PROG_PAR = 1'b0,
    PROG_SER = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/ofs_wr_regs.sv
`timescale 1ns/1ps
// Write-domain offset registers: defaults on master reset, parallel or serial loading.
module ofs_wr_regs
  import ofs_pkg::*;
#(
  parameter int W       = 10,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic         wclk,
  input  logic         mrst,
  input  logic         prst,
  input  logic         ld,
  input  logic         sen,
  input  logic         si,
  input  logic         wen,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ae,
  output logic [W-1:0] af,
  output prog_mode_e   mode
);
  localparam int BITS = 2 * W;
  localparam int CW   = $clog2(BITS);

  logic [CW-1:0]   bidx;
  logic            wsel;
  logic [BITS-1:0] shifted;

  // Place the incoming serial bit into the combined {af, ae} word.
  always_comb begin
    shifted       = {af, ae};
    shifted[bidx] = si;
  end

  always_ff @(posedge wclk) begin
    if (mrst) begin
      mode <= prog_mode_e'(ld);
      ae   <= ld ? W'(DEF_SER) : W'(DEF_PAR);
      af   <= ld ? W'(DEF_SER) : W'(DEF_PAR);
      bidx <= '0;
      wsel <= 1'b0;
    end else if (prst) begin
      bidx <= '0;
      wsel <= 1'b0;
    end else if (mode == PROG_PAR && wen && ld) begin
      if (wsel) af <= wdata;
      else      ae <= wdata;
      wsel <= ~wsel;
    end else if (mode == PROG_SER && sen && ld) begin
      ae   <= shifted[W-1:0];
      af   <= shifted[BITS-1:W];
      bidx <= (bidx == CW'(BITS - 1)) ? '0 : bidx + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_cdc.sv
`timescale 1ns/1ps
// Toggle request/acknowledge transfer of the offset pair into the read clock domain.
module ofs_cdc #(
  parameter int W       = 10,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst,
  input  logic         ld,
  input  logic [W-1:0] wr_ae,
  input  logic [W-1:0] wr_af,
  output logic [W-1:0] snap_ae,
  output logic [W-1:0] snap_af,
  output logic         busy,
  output logic [W-1:0] rd_ae,
  output logic [W-1:0] rd_af
);
  logic req, ack_m, ack_s;
  logic req_m, req_s, req_d;

  assign busy = req ^ ack_s;

  // Write side: capture a new snapshot only when no transfer is in flight.
  always_ff @(posedge wclk) begin
    if (mrst) begin
      req     <= 1'b0;
      ack_m   <= 1'b0;
      ack_s   <= 1'b0;
      snap_ae <= ld ? W'(DEF_SER) : W'(DEF_PAR);
      snap_af <= ld ? W'(DEF_SER) : W'(DEF_PAR);
    end else begin
      ack_m <= req_d;
      ack_s <= ack_m;
      if (!busy && ({snap_af, snap_ae} != {wr_af, wr_ae})) begin
        snap_ae <= wr_ae;
        snap_af <= wr_af;
        req     <= ~req;
      end
    end
  end

  // Read side: a toggle edge on the synchronised request loads the copies.
  always_ff @(posedge rclk) begin
    if (mrst) begin
      req_m <= 1'b0;
      req_s <= 1'b0;
      req_d <= 1'b0;
      rd_ae <= ld ? W'(DEF_SER) : W'(DEF_PAR);
      rd_af <= ld ? W'(DEF_SER) : W'(DEF_PAR);
    end else begin
      req_m <= req;
      req_s <= req_m;
      req_d <= req_s;
      if (req_s != req_d) begin
        rd_ae <= snap_ae;
        rd_af <= snap_af;
      end
    end
  end
endmodule

// File: rtl/ofs_rd_port.sv
`timescale 1ns/1ps
// Read-domain readback of the offset copies, alternating between the two.
module ofs_rd_port #(
  parameter int W = 10
) (
  input  logic         rclk,
  input  logic         mrst,
  input  logic         prst,
  input  logic         ren,
  input  logic         ld,
  input  logic [W-1:0] ae,
  input  logic [W-1:0] af,
  output logic [W-1:0] q
);
  logic rsel;

  always_ff @(posedge rclk) begin
    if (mrst) begin
      q    <= '0;
      rsel <= 1'b0;
    end else if (prst) begin
      rsel <= 1'b0;
    end else if (ren && ld) begin
      q    <= rsel ? af : ae;
      rsel <= ~rsel;
    end
  end
endmodule

// File: rtl/flag_offset_loader.sv
`timescale 1ns/1ps
module flag_offset_loader
  import ofs_pkg::*;
#(
  parameter int W       = 10,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst,
  input  logic         prst,
  input  logic         ld,
  input  logic         sen,
  input  logic         si,
  input  logic         wen,
  input  logic [W-1:0] wdata,
  input  logic         ren,
  output logic [W-1:0] rq,
  output logic         ser_mode,
  output logic [W-1:0] wr_ae_ofs,
  output logic [W-1:0] wr_af_ofs,
  output logic [W-1:0] rd_ae_ofs,
  output logic [W-1:0] rd_af_ofs
);
  prog_mode_e   mode;
  logic [W-1:0] hs_snap_ae, hs_snap_af;
  logic         hs_busy;

  assign ser_mode = (mode == PROG_SER);

  ofs_wr_regs #(.W(W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_wr (
    .wclk(wclk), .mrst(mrst), .prst(prst), .ld(ld), .sen(sen), .si(si),
    .wen(wen), .wdata(wdata), .ae(wr_ae_ofs), .af(wr_af_ofs), .mode(mode)
  );

  ofs_cdc #(.W(W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_cdc (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .ld(ld),
    .wr_ae(wr_ae_ofs), .wr_af(wr_af_ofs),
    .snap_ae(hs_snap_ae), .snap_af(hs_snap_af), .busy(hs_busy),
    .rd_ae(rd_ae_ofs), .rd_af(rd_af_ofs)
  );

  ofs_rd_port #(.W(W)) u_rd (
    .rclk(rclk), .mrst(mrst), .prst(prst), .ren(ren), .ld(ld),
    .ae(rd_ae_ofs), .af(rd_af_ofs), .q(rq)
  );
endmodule

// File: rtl/flag_offset_loader_chk.sv
`timescale 1ns/1ps
module flag_offset_loader_chk #(
  parameter int W       = 10,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input logic         wclk,
  input logic         rclk,
  input logic         mrst,
  input logic         prst,
  input logic         ld,
  input logic         sen,
  input logic         wen,
  input logic         ren,
  input logic [W-1:0] rq,
  input logic         ser_mode,
  input logic [W-1:0] wr_ae_ofs,
  input logic [W-1:0] wr_af_ofs,
  input logic [W-1:0] rd_ae_ofs,
  input logic [W-1:0] rd_af_ofs,
  input logic         hs_busy,
  input logic [W-1:0] hs_snap_ae,
  input logic [W-1:0] hs_snap_af
);
  AST_MRST_DEFAULT: assert property (@(posedge wclk) mrst |=> (ser_mode == $past(ld)) && (wr_ae_ofs == ($past(ld) ? W'(DEF_SER) : W'(DEF_PAR))) && (wr_af_ofs == ($past(ld) ? W'(DEF_SER) : W'(DEF_PAR)))); // R1
  AST_PAR_IGNORES_SEN: assert property (@(posedge wclk) disable iff (mrst) (!ser_mode && !(wen && ld)) |=> $stable(wr_ae_ofs) && $stable(wr_af_ofs)); // R3
  AST_SER_IGNORES_WEN: assert property (@(posedge wclk) disable iff (mrst) (ser_mode && !(sen && ld)) |=> $stable(wr_ae_ofs) && $stable(wr_af_ofs)); // R5
  AST_RQ_HOLDS: assert property (@(posedge rclk) disable iff (mrst) !(ren && ld) |=> $stable(rq)); // R6
  AST_SNAP_FROZEN: assert property (@(posedge wclk) disable iff (mrst) hs_busy |=> $stable(hs_snap_ae) && $stable(hs_snap_af)); // R7
  AST_COPY_FROM_SNAP: assert property (@(posedge rclk) disable iff (mrst) (!$stable(rd_ae_ofs) || !$stable(rd_af_ofs)) |-> (rd_ae_ofs == hs_snap_ae) && (rd_af_ofs == hs_snap_af)); // R7
  AST_PRST_KEEPS: assert property (@(posedge wclk) disable iff (mrst) prst |=> $stable(wr_ae_ofs) && $stable(wr_af_ofs) && $stable(ser_mode)); // R8
endmodule

bind flag_offset_loader flag_offset_loader_chk #(.W(W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_chk (.*);

// File: tb/flag_offset_loader_test.sv
`timescale 1ns/1ps
module flag_offset_loader_test;
  localparam int W = 4;
  localparam int DP = 7;
  localparam int DS = 13;

  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0, ld = 0, sen = 0, si = 0, wen = 0, ren = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rq, wr_ae_ofs, wr_af_ofs, rd_ae_ofs, rd_af_ofs;
  logic ser_mode;
  int vecs = 0, bad = 0;
  logic [W-1:0] v;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  flag_offset_loader #(.W(W), .DEF_PAR(DP), .DEF_SER(DS)) uut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ld(ld), .sen(sen),
    .si(si), .wen(wen), .wdata(wdata), .ren(ren), .rq(rq), .ser_mode(ser_mode),
    .wr_ae_ofs(wr_ae_ofs), .wr_af_ofs(wr_af_ofs),
    .rd_ae_ofs(rd_ae_ofs), .rd_af_ofs(rd_af_ofs)
  );

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pwrite(logic [W-1:0] d);
    @(negedge wclk); wen = 1; ld = 1; wdata = d;
    @(negedge wclk); wen = 0; ld = 0;
  endtask

  task automatic sbit(logic b);
    @(negedge wclk); sen = 1; ld = 1; si = b;
    @(negedge wclk); sen = 0; ld = 0;
  endtask

  task automatic rdback(output logic [W-1:0] q);
    @(negedge rclk); ren = 1; ld = 1;
    @(negedge rclk); ren = 0; ld = 0; q = rq;
  endtask

  task automatic settle();
    repeat (30) @(negedge wclk);
  endtask

  task automatic master(logic sel);
    @(negedge wclk); mrst = 1; ld = sel;
    repeat (4) @(negedge rclk);
    @(negedge wclk); mrst = 0; ld = 0;
    @(negedge wclk);
  endtask

  task automatic partial();
    @(negedge wclk); prst = 1;
    repeat (2) @(negedge rclk);
    @(negedge wclk); prst = 0;
  endtask

  task automatic chk_defaults(string tag, int m, int d);
    chk({tag, " mode"}, ser_mode, m);
    chk({tag, " wr_ae"}, wr_ae_ofs, d);
    chk({tag, " wr_af"}, wr_af_ofs, d);
    chk({tag, " rd_ae"}, rd_ae_ofs, d);
    chk({tag, " rd_af"}, rd_af_ofs, d);
    chk({tag, " rq"}, rq, 0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    // R1: parallel defaults
    master(1'b0);
    chk_defaults("R1 par", 0, DP);
    // R6: readback of defaults
    rdback(v); chk("R6 rd ae default", v, DP);
    rdback(v); chk("R6 rd af default", v, DP);
    partial();
    // R2, R7, R6: exhaustive parallel sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pwrite(W'(a)); chk("R2 ae load", wr_ae_ofs, a);
        pwrite(W'(b)); chk("R2 af load", wr_af_ofs, b);
        settle();
        chk("R7 rd_ae copy", rd_ae_ofs, a);
        chk("R7 rd_af copy", rd_af_ofs, b);
        rdback(v); chk("R6 rd ae par", v, a);
        rdback(v); chk("R6 rd af par", v, b);
      end
    end
    // R3: serial strobes ignored in parallel mode (state 15/15)
    sbit(1'b0); sbit(1'b0);
    chk("R3 ae untouched", wr_ae_ofs, 15);
    chk("R3 af untouched", wr_af_ofs, 15);
    // R8: partial reset rewinds indices, keeps values
    pwrite(4'd3);
    partial();
    chk("R8 ae kept", wr_ae_ofs, 3);
    chk("R8 af kept", wr_af_ofs, 15);
    chk("R8 mode kept", ser_mode, 0);
    pwrite(4'd9);
    chk("R8 write index to ae", wr_ae_ofs, 9);
    chk("R8 af unchanged", wr_af_ofs, 15);
    @(negedge wclk); prst = 1; wen = 1; ld = 1; wdata = 4'd1;
    @(negedge wclk); prst = 0; wen = 0; ld = 0;
    chk("R8 load blocked ae", wr_ae_ofs, 9);
    chk("R8 load blocked af", wr_af_ofs, 15);
    settle();
    rdback(v);
    partial();
    rdback(v); chk("R8 read index to ae", v, 9);
    // R1: serial defaults
    master(1'b1);
    chk_defaults("R1 ser", 1, DS);
    // R5: parallel strobes ignored in serial mode
    pwrite(4'd2);
    chk("R5 ae untouched", wr_ae_ofs, DS);
    chk("R5 af untouched", wr_af_ofs, DS);
    // R4: exhaustive serial sweep
    for (int p = 0; p < 256; p++) begin
      int prev_af;
      prev_af = wr_af_ofs;
      for (int k = 0; k < W; k++) sbit(p[k]);
      chk("R4 ae shifted", wr_ae_ofs, p % 16);
      chk("R4 af waits", wr_af_ofs, prev_af);
      for (int k = W; k < 2 * W; k++) sbit(p[k]);
      chk("R4 af shifted", wr_af_ofs, p / 16);
      settle();
      chk("R7 rd_ae copy ser", rd_ae_ofs, p % 16);
      chk("R7 rd_af copy ser", rd_af_ofs, p / 16);
      rdback(v); chk("R6 rd ae ser", v, p % 16);
      rdback(v); chk("R6 rd af ser", v, p / 16);
    end
    // R8: serial bit index rewinds
    sbit(1'b1); sbit(1'b1);
    partial();
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b0);
    chk("R8 serial index to ae", wr_ae_ofs, 5);
    chk("R8 mode kept ser", ser_mode, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule